// File: doc/BRIEF.md
# Control-Transfer Target Address Generator

This unit works out the destination address of a jump, call or branch. It takes the 24-bit address of the first byte of the following instruction, a mode code, an immediate operand and a register value, and forms the target in one of eight ways. Four ways are direct: a signed 8-bit relative add, a splice that keeps the current 2 KB block, a splice that keeps the current 64 KB region, and a full 24-bit replace. The other four are register-indirect, through a word register or a dword register, each with or without a signed 16-bit displacement.

The instruction decoder pulses `start_i` together with the mode and operands. One clock later the target appears on `target_o` with a one-cycle `valid_o` strobe. An unknown mode code produces the unchanged next-instruction address and sets `err_o`. The result and error flag stay on the outputs until the next start. Fetch, decode and the register file sit outside this unit.

Top module: `xfer_target_gen`

## Requirements
- R1: After reset, and before any start, `valid_o` is 0, `target_o` is 0 and `err_o` is 0.
- R2: Mode 0 (relative): target = next address + imm[7:0] read as a two's complement byte (-128..+127), modulo 2^24.
- R3: Mode 1 (block): target = {next[23:11], imm[10:0]}, so the target stays in the same 2 KB block.
- R4: Mode 2 (region): target = {next[23:16], imm[15:0]}, so the target stays in the same 64 KB region.
- R5: Mode 3 (absolute): target = imm[23:0].
- R6: Mode 4 (word indirect): target = {8'h00, reg[15:0]}, always inside region 00.
- R7: Mode 5 (word indirect plus displacement): target = {8'h00, (reg[15:0] + imm[15:0]) mod 2^16}, so the sum wraps inside region 00.
- R8: Mode 6 (dword indirect): target = reg[23:0], anywhere in 00:0000h..FF:FFFFh.
- R9: Mode 7 (dword indirect plus displacement): target = (reg[23:0] + imm[15:0] sign-extended to 24 bits) mod 2^24.
- R10: Mode codes 8..15 are unsupported: target = next address unchanged and `err_o` = 1. Modes 0..7 give `err_o` = 0.
- R11: `valid_o` is 1 for exactly the one cycle after each cycle with `start_i` high. Without a start, `target_o` and `err_o` hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Compute and register a target this cycle |
| mode_i | input | 4 | Mode code (0..7 supported, 8..15 unsupported) |
| next_pc_i | input | 24 | Address of the first byte of the next instruction |
| imm_i | input | 24 | Immediate operand: offset, partial or full address, or displacement in [15:0] |
| reg_i | input | 24 | Register value (word forms use [15:0], dword forms use [23:0]) |
| target_o | output | 24 | Registered target address |
| valid_o | output | 1 | One-cycle strobe: a new target is on `target_o` |
| err_o | output | 1 | The last start used an unsupported mode |

## Verification
Each mode has one merge rule. A wrong merge shows on `target_o` in the cycle right after the start as a bad high field: a block or region prefix that is not kept, or a nonzero region byte on a word-indirect target. A sign or wrap fault in the adders shows only with operands that cross a boundary, so the stimulus uses negative offsets below address zero, displacements that wrap inside region 00, and a dword sum that wraps through zero. A broken output register shows as a valid strobe that lasts too long, a missing strobe, or a target that drifts while no start is given. The next idle cycle exposes any of these.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [3:0] {
    XM_REL8      = 4'd0,
    XM_BLK11     = 4'd1,
    XM_RGN16     = 4'd2,
    XM_ABS24     = 4'd3,
    XM_WIND      = 4'd4,
    XM_WIND_DISP = 4'd5,
    XM_DIND      = 4'd6,
    XM_DIND_DISP = 4'd7
  } xfer_mode_e;

  localparam int unsigned XFER_MODE_W = 4;

endpackage

// File: rtl/xfer_direct_calc.sv
module xfer_direct_calc
  import xfer_pkg::*;
#(
  parameter int unsigned AW   = 24,
  parameter int unsigned RELW = 8,
  parameter int unsigned BLKW = 11,
  parameter int unsigned RGNW = 16
) (
  input  logic [XFER_MODE_W-1:0] mode,
  input  logic [AW-1:0]          next_pc,
  input  logic [AW-1:0]          imm,
  output logic [AW-1:0]          tgt,
  output logic                   hit
);

  localparam logic [AW-1:0] BLK_MASK = AW'((64'd1 << BLKW) - 64'd1);
  localparam logic [AW-1:0] RGN_MASK = AW'((64'd1 << RGNW) - 64'd1);

  function automatic logic [AW-1:0] f_rel(input logic [AW-1:0] base,
                                          input logic [RELW-1:0] off);
    return base + AW'($signed(off));
  endfunction

  function automatic logic [AW-1:0] f_splice(input logic [AW-1:0] base,
                                             input logic [AW-1:0] val,
                                             input logic [AW-1:0] mask);
    return (base & ~mask) | (val & mask);
  endfunction

  always_comb begin
    tgt = next_pc;
    hit = 1'b1;
    case (mode)
      XM_REL8:  tgt = f_rel(next_pc, imm[RELW-1:0]);
      XM_BLK11: tgt = f_splice(next_pc, imm, BLK_MASK);
      XM_RGN16: tgt = f_splice(next_pc, imm, RGN_MASK);
      XM_ABS24: tgt = imm;
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/xfer_indirect_calc.sv
module xfer_indirect_calc
  import xfer_pkg::*;
#(
  parameter int unsigned AW    = 24,
  parameter int unsigned WW    = 16,
  parameter int unsigned DISPW = 16
) (
  input  logic [XFER_MODE_W-1:0] mode,
  input  logic [AW-1:0]          reg_v,
  input  logic [DISPW-1:0]       disp,
  output logic [AW-1:0]          tgt,
  output logic                   hit
);

  localparam int unsigned PADW = AW - WW;

  function automatic logic [AW-1:0] f_word(input logic [WW-1:0] base,
                                           input logic [DISPW-1:0] d,
                                           input logic use_d);
    logic [WW-1:0] sum;
    sum = base + (use_d ? WW'($signed(d)) : '0);
    return {{PADW{1'b0}}, sum};
  endfunction

  function automatic logic [AW-1:0] f_dword(input logic [AW-1:0] base,
                                            input logic [DISPW-1:0] d,
                                            input logic use_d);
    return base + (use_d ? AW'($signed(d)) : '0);
  endfunction

  always_comb begin
    tgt = '0;
    hit = 1'b1;
    case (mode)
      XM_WIND:      tgt = f_word(reg_v[WW-1:0], disp, 1'b0);
      XM_WIND_DISP: tgt = f_word(reg_v[WW-1:0], disp, 1'b1);
      XM_DIND:      tgt = f_dword(reg_v, disp, 1'b0);
      XM_DIND_DISP: tgt = f_dword(reg_v, disp, 1'b1);
      default:      hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/xfer_target_gen.sv
module xfer_target_gen
  import xfer_pkg::*;
#(
  parameter int unsigned AW    = 24,
  parameter int unsigned RELW  = 8,
  parameter int unsigned BLKW  = 11,
  parameter int unsigned RGNW  = 16,
  parameter int unsigned WW    = 16,
  parameter int unsigned DISPW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [XFER_MODE_W-1:0] mode_i,
  input  logic [AW-1:0]          next_pc_i,
  input  logic [AW-1:0]          imm_i,
  input  logic [AW-1:0]          reg_i,
  output logic [AW-1:0]          target_o,
  output logic                   valid_o,
  output logic                   err_o
);

  logic [AW-1:0] dir_tgt;
  logic [AW-1:0] ind_tgt;
  logic [AW-1:0] nxt_tgt;
  logic          dir_hit;
  logic          ind_hit;
  logic          mode_bad;

  xfer_direct_calc #(
    .AW(AW), .RELW(RELW), .BLKW(BLKW), .RGNW(RGNW)
  ) u_direct (
    .mode    (mode_i),
    .next_pc (next_pc_i),
    .imm     (imm_i),
    .tgt     (dir_tgt),
    .hit     (dir_hit)
  );

  xfer_indirect_calc #(
    .AW(AW), .WW(WW), .DISPW(DISPW)
  ) u_indirect (
    .mode  (mode_i),
    .reg_v (reg_i),
    .disp  (imm_i[DISPW-1:0]),
    .tgt   (ind_tgt),
    .hit   (ind_hit)
  );

  assign mode_bad = !(dir_hit || ind_hit);

  always_comb begin
    if (dir_hit)      nxt_tgt = dir_tgt;
    else if (ind_hit) nxt_tgt = ind_tgt;
    else              nxt_tgt = next_pc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_o <= '0;
      err_o    <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        target_o <= nxt_tgt;
        err_o    <= mode_bad;
      end
    end
  end

endmodule

// File: rtl/xfer_target_chk.sv
module xfer_target_chk #(
  parameter int unsigned AW   = 24,
  parameter int unsigned BLKW = 11,
  parameter int unsigned RGNW = 16,
  parameter int unsigned WW   = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [3:0]    mode_i,
  input logic [AW-1:0] next_pc_i,
  input logic [AW-1:0] imm_i,
  input logic [AW-1:0] target_o,
  input logic          valid_o,
  input logic          err_o,
  input logic          dir_hit,
  input logic          ind_hit
);

  p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);

  p_valid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !valid_o);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(target_o) && $stable(err_o)));

  p_bad_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && mode_i[3]) |=> (err_o && target_o == $past(next_pc_i)));

  p_good_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !mode_i[3]) |=> !err_o);

  p_one_path_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(dir_hit && ind_hit));

  p_block_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && mode_i == 4'd1) |=> target_o[AW-1:BLKW] == $past(next_pc_i[AW-1:BLKW]));

  p_region_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && mode_i == 4'd2) |=> target_o[AW-1:RGNW] == $past(next_pc_i[AW-1:RGNW]));

  p_abs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && mode_i == 4'd3) |=> target_o == $past(imm_i));

  p_word_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (mode_i == 4'd4 || mode_i == 4'd5)) |=> target_o[AW-1:WW] == '0);

endmodule

bind xfer_target_gen xfer_target_chk #(
  .AW(AW), .BLKW(BLKW), .RGNW(RGNW), .WW(WW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .mode_i    (mode_i),
  .next_pc_i (next_pc_i),
  .imm_i     (imm_i),
  .target_o  (target_o),
  .valid_o   (valid_o),
  .err_o     (err_o),
  .dir_hit   (dir_hit),
  .ind_hit   (ind_hit)
);

// File: tb/xfer_target_gen_tb.sv
`timescale 1ns/1ps
module xfer_target_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [23:0] next_pc_i = '0;
  logic [23:0] imm_i = '0;
  logic [23:0] reg_i = '0;
  logic [23:0] target_o;
  logic        valid_o;
  logic        err_o;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    logic [23:0] tgt;
    logic        err;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  xfer_target_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .next_pc_i(next_pc_i), .imm_i(imm_i), .reg_i(reg_i),
    .target_o(target_o), .valid_o(valid_o), .err_o(err_o)
  );

  function automatic void model(input logic [3:0] m, input logic [23:0] nx,
                                input logic [23:0] im, input logic [23:0] rg,
                                output logic [23:0] t, output logic e);
    int s;
    e = 1'b0;
    case (m)
      4'd0: begin
        s = int'(nx) + int'($signed(im[7:0]));
        t = s[23:0];
      end
      4'd1: t = {nx[23:11], im[10:0]};
      4'd2: t = {nx[23:16], im[15:0]};
      4'd3: t = im;
      4'd4: t = {8'h00, rg[15:0]};
      4'd5: begin
        s = int'(rg[15:0]) + int'(im[15:0]);
        t = {8'h00, s[15:0]};
      end
      4'd6: t = rg;
      4'd7: begin
        s = int'(rg) + int'($signed(im[15:0]));
        t = s[23:0];
      end
      default: begin
        t = nx;
        e = 1'b1;
      end
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [23:0] act,
                       input logic [23:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] m, input logic [23:0] nx,
                       input logic [23:0] im, input logic [23:0] rg,
                       input string tag);
    exp_t it;
    @(negedge clk);
    mode_i = m; next_pc_i = nx; imm_i = im; reg_i = rg; start_i = 1'b1;
    model(m, nx, im, rg, it.tgt, it.err);
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // monitor: pop and compare on every valid strobe, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R11 unexpected valid", {23'd0, valid_o}, 24'd0);
      end else begin
        exp_t it;
        it = sb_q.pop_front();
        check(target_o === it.tgt, it.tag, target_o, it.tgt);
        check(err_o === it.err, {it.tag, " err flag R10"}, {23'd0, err_o}, {23'd0, it.err});
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    check(1'b0, "watchdog expired", 24'd0, 24'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [23:0] held;
    logic        held_err;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(valid_o === 1'b0, "R1 valid after reset", {23'd0, valid_o}, 24'd0);
    check(target_o === 24'd0, "R1 target after reset", target_o, 24'd0);
    check(err_o === 1'b0, "R1 err after reset", {23'd0, err_o}, 24'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid_o === 1'b0, "R1 valid before start", {23'd0, valid_o}, 24'd0);

    drive(4'd0, 24'h12_3400, 24'h000005, 24'h0, "R2 rel +5");
    drive(4'd0, 24'h00_0010, 24'h000080, 24'h0, "R2 rel -128 wraps below zero");
    drive(4'd0, 24'h00_07F0, 24'h00007F, 24'h0, "R2 rel +127 crosses block");
    drive(4'd1, 24'hAB_CFFE, 24'hFFF123, 24'h0, "R3 block splice");
    drive(4'd2, 24'h7E_FFFF, 24'h550001, 24'h0, "R4 region splice");
    drive(4'd3, 24'h01_0000, 24'hFEDCBA, 24'h0, "R5 absolute");
    drive(4'd4, 24'h33_0000, 24'h0, 24'hAB_9876, "R6 word indirect");
    drive(4'd5, 24'h33_0000, 24'h000020, 24'h12_FFF0, "R7 word disp wrap up");
    drive(4'd5, 24'h33_0000, 24'h00FFF0, 24'h00_0004, "R7 word disp wrap down");
    drive(4'd6, 24'h00_0000, 24'h0, 24'hC0_FFEE, "R8 dword indirect");
    drive(4'd7, 24'h00_0000, 24'h00FFF0, 24'h00_0004, "R9 dword neg disp wraps");
    drive(4'd7, 24'h00_0000, 24'h007FFF, 24'h01_8001, "R9 dword pos disp carry");
    drive(4'd8, 24'h45_6789, 24'h111111, 24'h222222, "R10 mode 8 unsupported");
    drive(4'd15, 24'h00_ABCD, 24'h333333, 24'h444444, "R10 mode 15 unsupported");
    drive(4'd3, 24'h00_0000, 24'h0A0B0C, 24'h0, "R10 err clears on good mode");

    // R11: hold while idle, single-cycle valid
    @(negedge clk);
    held = target_o;
    held_err = err_o;
    mode_i = 4'd9; next_pc_i = 24'hFFFFFF; imm_i = 24'h123456; reg_i = 24'h654321;
    repeat (4) begin
      @(negedge clk);
      check(valid_o === 1'b0, "R11 valid stays low without start", {23'd0, valid_o}, 24'd0);
      check(target_o === held, "R11 target holds without start", target_o, held);
      check(err_o === held_err, "R11 err holds without start", {23'd0, err_o}, {23'd0, held_err});
    end
    check(sb_q.size() == 0, "R11 every start gave one valid", 24'(sb_q.size()), 24'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule